// File: doc/BRIEF.md
# Quality-Ranked Event Slot Manager

This block keeps track of a fixed pool of storage slots for captured waveform events. Every occupied slot holds a quality score. A producer that has a fresh event asks for a slot. It gets a free slot if there is one. If the pool is full, it gets the slot of the weakest stored event, which is overwritten. The telemetry side asks for the next event to send. It gets the strongest stored event, and that slot is freed at once. Software may rewrite the score of any stored event at any time, so that an event can be promoted or demoted after it was captured.

A mode input makes the pool ignore scores. In that mode, both the output choice and the overwrite choice take the oldest stored event. The sample sent down is then unbiased by the scoring rules. The block only manages slot numbers and scores. Computing scores and moving event data are done elsewhere.

Any request is answered by a one-cycle strobe in the next cycle. When several requests arrive in the same cycle, they are applied in a fixed order: the score rewrite first, then the read, then the allocation.

Top module: `evslot_mgr`

## Requirements
- R1: After reset every slot is free and all outputs are low or zero. A read issued right after reset reports an empty pool.
- R2: `done_o` is high in the cycle after any cycle in which at least one request input is high, and low in every other cycle. All result outputs are valid only while `done_o` is high and are zero otherwise.
- R3: An allocation made while a free slot exists returns the lowest-numbered free slot. It sets `alloc_ok_o`, keeps `alloc_evicted_o` low, and the slot then holds the supplied score.
- R4: In score mode, an allocation into a full pool overwrites the occupied slot with the lowest score. Among equal lowest scores, the slot allocated most recently is chosen. The block reports that slot in `alloc_idx_o` with `alloc_evicted_o` high.
- R5: In score mode, a read on a non-empty pool returns the occupied slot with the highest score, in `rd_idx_o` and `rd_score_o`, with `rd_hit_o` high. Among equal highest scores, the slot allocated earliest is chosen. That slot becomes free.
- R6: A read on an empty pool sets `rd_empty_o` and keeps `rd_hit_o` low. Both `rd_idx_o` and `rd_score_o` are zero.
- R7: A score update to an occupied slot replaces its score, and later reads and evictions use the new score. An update aimed at a free slot, or at an index of `NUM_SLOTS` or above, changes nothing.
- R8: While `blind_i` is high, reads and full-pool allocations both select the occupied slot that was allocated earliest, whatever the scores.
- R9: Requests in the same cycle are applied in this order: update, then read, then allocate. The read sees the updated score. The allocation sees the slot freed by the read, so it does not overwrite when the read succeeded.
- R10: Arrival order is kept across reads and overwrites. A slot that is overwritten or refilled counts as the newest event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| blind_i | input | 1 | 1: select by arrival order; 0: select by score |
| alloc_req_i | input | 1 | Request a slot for a new event |
| alloc_score_i | input | SCORE_W | Score of the new event |
| rd_req_i | input | 1 | Telemetry asks for the next event |
| upd_req_i | input | 1 | Rewrite the score of a stored event |
| upd_idx_i | input | IDX_W | Slot whose score is rewritten |
| upd_score_i | input | SCORE_W | New score |
| done_o | output | 1 | Response strobe, one cycle after any request |
| alloc_ok_o | output | 1 | Allocation served |
| alloc_evicted_o | output | 1 | Allocation overwrote a stored event |
| alloc_idx_o | output | IDX_W | Slot given to the new event |
| rd_hit_o | output | 1 | Read returned an event |
| rd_empty_o | output | 1 | Read found the pool empty |
| rd_idx_o | output | IDX_W | Slot returned to telemetry |
| rd_score_o | output | SCORE_W | Score of the returned slot |

IDX_W is ceil(log2(NUM_SLOTS)).

## Verification
The bench builds the manager with six slots and four-bit scores. With six slots, the pool fills and starts overwriting within a few allocations. With sixteen score values, equal scores occur often, so both tie-break directions are exercised constantly. A three-bit index also lets the bench send updates to indices 6 and 7, which exist on the bus but not in the pool. A long random mix of simultaneous requests and mode changes then keeps arrival ranks shifting after every read and overwrite.

// File: rtl/evslot_pkg.sv
package evslot_pkg;

    // Direction of a score-based search.
    typedef enum logic {
        PICK_BEST  = 1'b0,
        PICK_WORST = 1'b1
    } pick_e;

endpackage

// File: rtl/evslot_pick.sv
// Linear search over all slots for the best, worst or oldest occupied entry.
// Rank 0 is the oldest occupied slot; ranks are unique among occupied slots.
module evslot_pick
    import evslot_pkg::*;
#(
    parameter int NUM_SLOTS = 20,
    parameter int SCORE_W   = 8,
    parameter int IDX_W     = 5
) (
    input  logic [NUM_SLOTS-1:0]         occ_i,
    input  logic [NUM_SLOTS*SCORE_W-1:0] score_i,
    input  logic [NUM_SLOTS*IDX_W-1:0]   rank_i,
    input  pick_e                        pick_i,
    input  logic                         blind_i,
    output logic                         found_o,
    output logic [IDX_W-1:0]             idx_o
);

    logic               cand_found;
    logic [IDX_W-1:0]   cand_idx;
    logic [SCORE_W-1:0] cand_score;
    logic [IDX_W-1:0]   cand_rank;
    logic [SCORE_W-1:0] cur_score;
    logic [IDX_W-1:0]   cur_rank;
    logic               better;

    always_comb begin
        cand_found = 1'b0;
        cand_idx   = '0;
        cand_score = '0;
        cand_rank  = '0;
        cur_score  = '0;
        cur_rank   = '0;
        better     = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            cur_score = score_i[i*SCORE_W +: SCORE_W];
            cur_rank  = rank_i[i*IDX_W +: IDX_W];
            if (blind_i) begin
                better = cur_rank < cand_rank;
            end else if (pick_i == PICK_BEST) begin
                better = (cur_score > cand_score) ||
                         ((cur_score == cand_score) && (cur_rank < cand_rank));
            end else begin
                better = (cur_score < cand_score) ||
                         ((cur_score == cand_score) && (cur_rank > cand_rank));
            end
            if (occ_i[i] && (!cand_found || better)) begin
                cand_found = 1'b1;
                cand_idx   = IDX_W'(i);
                cand_score = cur_score;
                cand_rank  = cur_rank;
            end
        end
    end

    assign found_o = cand_found;
    assign idx_o   = cand_idx;

endmodule

// File: rtl/evslot_free.sv
// Finds the lowest-numbered free slot.
module evslot_free #(
    parameter int NUM_SLOTS = 20,
    parameter int IDX_W     = 5
) (
    input  logic [NUM_SLOTS-1:0] occ_i,
    output logic                 found_o,
    output logic [IDX_W-1:0]     idx_o
);

    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
            if (!occ_i[i]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/evslot_mgr.sv
// Event slot pool: score-ranked read/evict with an arrival-order mode.
module evslot_mgr
    import evslot_pkg::*;
#(
    parameter int NUM_SLOTS = 20,
    parameter int SCORE_W   = 8,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               blind_i,
    input  logic               alloc_req_i,
    input  logic [SCORE_W-1:0] alloc_score_i,
    input  logic               rd_req_i,
    input  logic               upd_req_i,
    input  logic [IDX_W-1:0]   upd_idx_i,
    input  logic [SCORE_W-1:0] upd_score_i,
    output logic               done_o,
    output logic               alloc_ok_o,
    output logic               alloc_evicted_o,
    output logic [IDX_W-1:0]   alloc_idx_o,
    output logic               rd_hit_o,
    output logic               rd_empty_o,
    output logic [IDX_W-1:0]   rd_idx_o,
    output logic [SCORE_W-1:0] rd_score_o
);

    localparam int CNT_W = $clog2(NUM_SLOTS + 1);
    localparam logic [IDX_W-1:0] RANK_NEWEST = IDX_W'(NUM_SLOTS - 1);

    typedef struct packed {
        logic               occ;
        logic [SCORE_W-1:0] score;
        logic [IDX_W-1:0]   rank;
    } slot_t;

    typedef struct packed {
        slot_t [NUM_SLOTS-1:0] slot;
        logic [CNT_W-1:0]      count;
        logic                  done;
        logic                  alloc_ok;
        logic                  alloc_ev;
        logic [IDX_W-1:0]      alloc_idx;
        logic                  rd_hit;
        logic                  rd_empty;
        logic [IDX_W-1:0]      rd_idx;
        logic [SCORE_W-1:0]    rd_score;
    } state_t;

    state_t st_q, st_d;

    // Stage views: after score update, after read.
    slot_t [NUM_SLOTS-1:0] upd_s;
    slot_t [NUM_SLOTS-1:0] rdo_s;
    logic [CNT_W-1:0]      rdo_cnt;

    logic [NUM_SLOTS-1:0]         upd_occ, rdo_occ;
    logic [NUM_SLOTS*SCORE_W-1:0] upd_score_flat, rdo_score_flat;
    logic [NUM_SLOTS*IDX_W-1:0]   upd_rank_flat, rdo_rank_flat;

    logic               rd_found, ev_found, fr_found;
    logic [IDX_W-1:0]   rd_sel, ev_sel, fr_sel;
    logic               rd_go;
    logic [SCORE_W-1:0] rd_vscore;
    logic [IDX_W-1:0]   rd_vrank;
    logic [IDX_W-1:0]   ev_vrank;

    generate
        for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_flat
            assign upd_occ[g]                          = upd_s[g].occ;
            assign upd_score_flat[g*SCORE_W +: SCORE_W] = upd_s[g].score;
            assign upd_rank_flat[g*IDX_W +: IDX_W]      = upd_s[g].rank;
            assign rdo_occ[g]                          = rdo_s[g].occ;
            assign rdo_score_flat[g*SCORE_W +: SCORE_W] = rdo_s[g].score;
            assign rdo_rank_flat[g*IDX_W +: IDX_W]      = rdo_s[g].rank;
        end
    endgenerate

    // Stage 1: score rewrite, only for an occupied, in-range slot.
    always_comb begin
        upd_s = st_q.slot;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (upd_req_i && (upd_idx_i == IDX_W'(i)) && st_q.slot[i].occ) begin
                upd_s[i].score = upd_score_i;
            end
        end
    end

    evslot_pick #(
        .NUM_SLOTS(NUM_SLOTS), .SCORE_W(SCORE_W), .IDX_W(IDX_W)
    ) u_pick_rd (
        .occ_i   (upd_occ),
        .score_i (upd_score_flat),
        .rank_i  (upd_rank_flat),
        .pick_i  (PICK_BEST),
        .blind_i (blind_i),
        .found_o (rd_found),
        .idx_o   (rd_sel)
    );

    // Stage 2: read frees the selected slot and closes the rank gap.
    always_comb begin
        rdo_s     = upd_s;
        rdo_cnt   = st_q.count;
        rd_go     = rd_req_i && rd_found;
        rd_vscore = '0;
        rd_vrank  = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (rd_sel == IDX_W'(i)) begin
                rd_vscore = upd_s[i].score;
                rd_vrank  = upd_s[i].rank;
            end
        end
        if (rd_go) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (upd_s[i].occ && (upd_s[i].rank > rd_vrank)) begin
                    rdo_s[i].rank = upd_s[i].rank - IDX_W'(1);
                end
                if (rd_sel == IDX_W'(i)) begin
                    rdo_s[i] = '0;
                end
            end
            rdo_cnt = st_q.count - CNT_W'(1);
        end
    end

    evslot_pick #(
        .NUM_SLOTS(NUM_SLOTS), .SCORE_W(SCORE_W), .IDX_W(IDX_W)
    ) u_pick_ev (
        .occ_i   (rdo_occ),
        .score_i (rdo_score_flat),
        .rank_i  (rdo_rank_flat),
        .pick_i  (PICK_WORST),
        .blind_i (blind_i),
        .found_o (ev_found),
        .idx_o   (ev_sel)
    );

    evslot_free #(
        .NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)
    ) u_free (
        .occ_i   (rdo_occ),
        .found_o (fr_found),
        .idx_o   (fr_sel)
    );

    // Stage 3: allocation, response and next state.
    always_comb begin
        st_d           = st_q;
        st_d.slot      = rdo_s;
        st_d.count     = rdo_cnt;
        st_d.done      = alloc_req_i || rd_req_i || upd_req_i;
        st_d.rd_hit    = rd_go;
        st_d.rd_empty  = rd_req_i && !rd_found;
        st_d.rd_idx    = rd_go ? rd_sel : '0;
        st_d.rd_score  = rd_go ? rd_vscore : '0;
        st_d.alloc_ok  = 1'b0;
        st_d.alloc_ev  = 1'b0;
        st_d.alloc_idx = '0;
        ev_vrank       = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (ev_sel == IDX_W'(i)) begin
                ev_vrank = rdo_s[i].rank;
            end
        end
        if (alloc_req_i) begin
            if (fr_found) begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (fr_sel == IDX_W'(i)) begin
                        st_d.slot[i].occ   = 1'b1;
                        st_d.slot[i].score = alloc_score_i;
                        st_d.slot[i].rank  = IDX_W'(rdo_cnt);
                    end
                end
                st_d.count     = rdo_cnt + CNT_W'(1);
                st_d.alloc_ok  = 1'b1;
                st_d.alloc_idx = fr_sel;
            end else if (ev_found) begin
                for (int i = 0; i < NUM_SLOTS; i++) begin
                    if (rdo_s[i].occ && (rdo_s[i].rank > ev_vrank)) begin
                        st_d.slot[i].rank = rdo_s[i].rank - IDX_W'(1);
                    end
                    if (ev_sel == IDX_W'(i)) begin
                        st_d.slot[i].occ   = 1'b1;
                        st_d.slot[i].score = alloc_score_i;
                        st_d.slot[i].rank  = RANK_NEWEST;
                    end
                end
                st_d.alloc_ok  = 1'b1;
                st_d.alloc_ev  = 1'b1;
                st_d.alloc_idx = ev_sel;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign done_o          = st_q.done;
    assign alloc_ok_o      = st_q.alloc_ok;
    assign alloc_evicted_o = st_q.alloc_ev;
    assign alloc_idx_o     = st_q.alloc_idx;
    assign rd_hit_o        = st_q.rd_hit;
    assign rd_empty_o      = st_q.rd_empty;
    assign rd_idx_o        = st_q.rd_idx;
    assign rd_score_o      = st_q.rd_score;

endmodule

// File: rtl/evslot_chk.sv
// Port-level properties of the slot manager.
module evslot_chk #(
    parameter int NUM_SLOTS = 20,
    parameter int SCORE_W   = 8,
    localparam int IDX_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input logic               clk,
    input logic               rst_n,
    input logic               alloc_req_i,
    input logic               rd_req_i,
    input logic               upd_req_i,
    input logic               done_o,
    input logic               alloc_ok_o,
    input logic               alloc_evicted_o,
    input logic [IDX_W-1:0]   alloc_idx_o,
    input logic               rd_hit_o,
    input logic               rd_empty_o,
    input logic [IDX_W-1:0]   rd_idx_o,
    input logic [SCORE_W-1:0] rd_score_o
);

    localparam int CNT_W = $clog2(NUM_SLOTS + 1);

    // Occupancy as seen from the responses alone.
    logic [CNT_W-1:0] seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
        end else begin
            seen_q <= seen_q
                      + ((alloc_ok_o && !alloc_evicted_o) ? CNT_W'(1) : CNT_W'(0))
                      - (rd_hit_o ? CNT_W'(1) : CNT_W'(0));
        end
    end

    AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req_i || rd_req_i || upd_req_i) |=> done_o); // R2

    AST_NO_IDLE_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(alloc_req_i || rd_req_i || upd_req_i) |=> !done_o); // R2

    AST_ALLOC_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_req_i |=> (alloc_ok_o && (32'(alloc_idx_o) < NUM_SLOTS))); // R3

    AST_EVICT_ONLY_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_evicted_o |-> (alloc_ok_o && !rd_hit_o && (32'(seen_q) == NUM_SLOTS))); // R4

    AST_READ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> (rd_hit_o != rd_empty_o)); // R5

    AST_EMPTY_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rd_empty_o |-> (seen_q == '0 && rd_idx_o == '0 && rd_score_o == '0)); // R6

    AST_READ_BEFORE_ALLOC: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_i && alloc_req_i) |=> !(rd_hit_o && alloc_evicted_o)); // R9

endmodule

bind evslot_mgr evslot_chk #(.NUM_SLOTS(NUM_SLOTS), .SCORE_W(SCORE_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .alloc_req_i     (alloc_req_i),
    .rd_req_i        (rd_req_i),
    .upd_req_i       (upd_req_i),
    .done_o          (done_o),
    .alloc_ok_o      (alloc_ok_o),
    .alloc_evicted_o (alloc_evicted_o),
    .alloc_idx_o     (alloc_idx_o),
    .rd_hit_o        (rd_hit_o),
    .rd_empty_o      (rd_empty_o),
    .rd_idx_o        (rd_idx_o),
    .rd_score_o      (rd_score_o)
);

// File: tb/sim_evslot_mgr.sv
module sim_evslot_mgr;

    localparam int N  = 6;
    localparam int SW = 4;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          blind_i = 1'b0;
    logic          alloc_req_i = 1'b0;
    logic [SW-1:0] alloc_score_i = '0;
    logic          rd_req_i = 1'b0;
    logic          upd_req_i = 1'b0;
    logic [IW-1:0] upd_idx_i = '0;
    logic [SW-1:0] upd_score_i = '0;
    logic          done_o, alloc_ok_o, alloc_evicted_o, rd_hit_o, rd_empty_o;
    logic [IW-1:0] alloc_idx_o, rd_idx_o;
    logic [SW-1:0] rd_score_o;

    evslot_mgr #(.NUM_SLOTS(N), .SCORE_W(SW)) u0 (
        .clk, .rst_n, .blind_i, .alloc_req_i, .alloc_score_i, .rd_req_i,
        .upd_req_i, .upd_idx_i, .upd_score_i, .done_o, .alloc_ok_o,
        .alloc_evicted_o, .alloc_idx_o, .rd_hit_o, .rd_empty_o, .rd_idx_o,
        .rd_score_o
    );

    always #10 clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 0;

    // Reference model: occupancy, scores, arrival queue (front = oldest).
    bit m_occ[N];
    int m_sc[N];
    int order[$];

    int e_done, e_aok, e_aev, e_aidx, e_hit, e_emp, e_ridx, e_rsc;

    task automatic chk(string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic model(bit b, bit a, int as, bit r, bit u, int ui, int us);
        int pos;
        int fr;
        e_done = (a || r || u) ? 1 : 0;
        e_aok = 0; e_aev = 0; e_aidx = 0;
        e_hit = 0; e_emp = 0; e_ridx = 0; e_rsc = 0;
        if (u && ui < N) begin
            if (m_occ[ui]) m_sc[ui] = us;
        end
        if (r) begin
            if (order.size() == 0) begin
                e_emp = 1;
            end else begin
                pos = 0;
                for (int k = 1; k < order.size(); k++)
                    if (!b && m_sc[order[k]] > m_sc[order[pos]]) pos = k;
                e_hit = 1;
                e_ridx = order[pos];
                e_rsc = m_sc[order[pos]];
                m_occ[order[pos]] = 0;
                order.delete(pos);
            end
        end
        if (a) begin
            fr = -1;
            for (int k = N - 1; k >= 0; k--) if (!m_occ[k]) fr = k;
            e_aok = 1;
            if (fr >= 0) begin
                m_occ[fr] = 1;
                m_sc[fr] = as;
                order.push_back(fr);
                e_aidx = fr;
            end else begin
                pos = 0;
                for (int k = 1; k < order.size(); k++)
                    if (!b && m_sc[order[k]] <= m_sc[order[pos]]) pos = k;
                e_aidx = order[pos];
                e_aev = 1;
                m_sc[order[pos]] = as;
                order.delete(pos);
                order.push_back(e_aidx);
            end
        end
    endtask

    task automatic step(string tag, bit b, bit a, int as, bit r, bit u, int ui, int us);
        string rt, at;
        blind_i = b; alloc_req_i = a; alloc_score_i = SW'(as); rd_req_i = r;
        upd_req_i = u; upd_idx_i = IW'(ui); upd_score_i = SW'(us);
        model(b, a, as, r, u, ui, us);
        @(posedge clk);
        @(negedge clk);
        rt = e_emp ? "R6" : (b ? "R8" : "R5");
        at = e_aev ? (b ? "R8" : "R4") : "R3";
        chk({tag, " R2 done"}, int'(done_o), e_done);
        chk({tag, " ", rt, " rd_hit"}, int'(rd_hit_o), e_hit);
        chk({tag, " ", rt, " rd_empty"}, int'(rd_empty_o), e_emp);
        chk({tag, " ", rt, " rd_idx"}, int'(rd_idx_o), e_ridx);
        chk({tag, " ", rt, " rd_score"}, int'(rd_score_o), e_rsc);
        chk({tag, " ", at, " alloc_ok"}, int'(alloc_ok_o), e_aok);
        chk({tag, " ", at, " alloc_evicted"}, int'(alloc_evicted_o), e_aev);
        chk({tag, " ", at, " alloc_idx"}, int'(alloc_idx_o), e_aidx);
    endtask

    task automatic drain(string tag, bit b);
        while (order.size() > 0) step(tag, b, 0, 0, 1, 0, 0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 done after reset", int'(done_o), 0);
        chk("R1 rd_hit after reset", int'(rd_hit_o), 0);
        chk("R1 alloc_ok after reset", int'(alloc_ok_o), 0);
        step("R1", 0, 0, 0, 1, 0, 0, 0);
        step("R1 idle", 0, 0, 0, 0, 0, 0, 0);

        // Fill, then overwrite with ties (R3, R4)
        step("R3", 0, 1, 5, 0, 0, 0, 0);
        step("R3", 0, 1, 3, 0, 0, 0, 0);
        step("R3", 0, 1, 5, 0, 0, 0, 0);
        step("R3", 0, 1, 9, 0, 0, 0, 0);
        step("R3", 0, 1, 1, 0, 0, 0, 0);
        step("R3", 0, 1, 3, 0, 0, 0, 0);
        step("R4 lowest", 0, 1, 7, 0, 0, 0, 0);
        step("R4 tie newest", 0, 1, 2, 0, 0, 0, 0);
        chk("R4 tie goes to newer slot", int'(alloc_idx_o), 5);

        // Reads with ties (R5)
        step("R5", 0, 0, 0, 1, 0, 0, 0);
        step("R5", 0, 0, 0, 1, 0, 0, 0);
        step("R5 tie oldest", 0, 0, 0, 1, 0, 0, 0);
        chk("R5 tie goes to older slot", int'(rd_idx_o), 0);

        // Updates: occupied, free, out of range (R7)
        step("R7", 0, 0, 0, 0, 1, 2, 15);
        step("R7 free slot", 0, 0, 0, 0, 1, 3, 14);
        step("R7 out of range", 0, 0, 0, 0, 1, 7, 14);
        step("R7", 0, 0, 0, 1, 0, 0, 0);
        chk("R7 updated score read back", int'(rd_score_o), 15);
        step("R7", 0, 1, 4, 0, 0, 0, 0);
        step("R7", 0, 0, 0, 1, 0, 0, 0);
        drain("R7", 0);

        // Same-cycle ordering (R9)
        for (int k = 0; k < N; k++) step("R9 fill", 0, 1, k + 2, 0, 0, 0, 0);
        step("R9 all three", 0, 1, 0, 1, 1, 0, 15);
        chk("R9 read sees update", int'(rd_idx_o), 0);
        chk("R9 alloc reuses freed slot", int'(alloc_evicted_o), 0);
        step("R9 update then read", 0, 0, 0, 1, 1, 1, 0);
        drain("R9", 0);

        // Arrival order mode (R8, R10)
        for (int k = 0; k < N; k++) step("R8 fill", 1, 1, 15 - k, 0, 0, 0, 0);
        step("R8 evict oldest", 1, 1, 0, 0, 0, 0, 0);
        step("R10 evict next", 1, 1, 0, 0, 0, 0, 0);
        step("R10 read oldest", 1, 0, 0, 1, 0, 0, 0);
        step("R10 refill", 1, 1, 9, 0, 0, 0, 0);
        drain("R10", 1);

        // Mixed traffic
        for (int k = 0; k < 3000; k++) begin
            step("R10 mix", ($urandom % 4) == 0, ($urandom % 2) == 0, int'($urandom % 16),
                 ($urandom % 3) == 0, ($urandom % 3) == 0, int'($urandom % 8),
                 int'($urandom % 16));
        end

        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule